// File: doc/BRIEF.md
# Cascadable column data loader

This block collects one display line of pixel codes for a column driver with 384 output channels. Each rising edge of the shift clock presents a 36-bit word of six 6-bit codes. A start token arms the loader, and a one-hot token register then steps through 64 capture positions. At each position one six-channel group of the row register is written. When the last group has been written, the loader hands the token to the next device in the chain and stops. It then ignores the shift clock until a new start token arrives.

A direction input decides two things. It selects which start pin receives the token and which one forwards it. It also sets whether the row fills from the lowest channels upward or from the highest channels downward. An inversion input can complement each code as it is stored. A rising edge on the line-latch input stops any load that is in progress. The row register drives the downstream line latch, which is outside this block.

Top module: `col_loader`

## Requirements
- R1: Lane j of the input word (bits [6j+5:6j], bit 6j being the LSB) holds the code for the j-th channel of the group being written. Lane 0 always goes to the lowest channel of that group.
- R2: The start token is sampled on a clock edge. The word present on that same edge is discarded. The first word is captured on the following edge.
- R3: With dir_i high, sp_a_i is the start input and sp_b_o is the cascade output (sp_b_oe=1, sp_a_oe=0). With dir_i low, the two pins swap roles. A token on the output-side pin is ignored.
- R4: With dir_i high, word k (k=0..63) fills channels 6k+1..6k+6, that is row_o bits [(6k+j)*6 +: 6]. With dir_i low, word k fills group 63-k.
- R5: After 64 words the loader enters standby. Later words leave row_o unchanged until the next start token.
- R6: If inv_i is high on a capture edge, the complement of each code is stored. If it is low, the code is stored unchanged. Each word is treated on its own.
- R7: A rising edge of line_latch_i empties the token register, and the word on that edge is not stored. No word is captured after that until the next start token. Holding line_latch_i high does not block a new start.
- R8: The cascade output is high for exactly one cycle, between the capture of word 62 and the capture of word 63. The pin that is not the output stays low.
- R9: A synchronous reset clears row_o, empties the token register and holds both cascade outputs low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shift clock |
| rst | input | 1 | Synchronous reset, active high |
| line_latch_i | input | 1 | Line-latch strobe; its rising edge stops loading |
| dir_i | input | 1 | Fill direction and start-pin role select |
| inv_i | input | 1 | Store complemented codes when high |
| pix_i | input | 36 | Six 6-bit pixel codes |
| sp_a_i | input | 1 | Start pin A, input side |
| sp_a_o | output | 1 | Start pin A, output side |
| sp_a_oe | output | 1 | Start pin A output enable |
| sp_b_i | input | 1 | Start pin B, input side |
| sp_b_o | output | 1 | Start pin B, output side |
| sp_b_oe | output | 1 | Start pin B output enable |
| row_o | output | 2304 | Row register, 384 channels of 6 bits, channel 1 in the low bits |

## Verification
A word driven before edge k+1 after the start edge lands in row_o straight after that edge, because the row register is the only register on the data path. The cascade output is a decode of the token register, so it is high in the cycle after the edge that captured word 62. The bench drives inputs on falling edges and samples outputs on the falling edge that follows the capturing rising edge. Before each new word it reads the cascade pins, which pins the pulse to a single cycle. Standby, latch-clear and wrong-pin checks apply further clocks and then compare the complete row register with its earlier value.

// File: rtl/col_loader_pkg.sv
package col_loader_pkg;

   typedef enum logic {
      FILL_DOWN = 1'b0,
      FILL_UP   = 1'b1
   } fill_dir_e;

   // Row group that receives capture step 'step' for a given fill direction.
   function automatic int unsigned slot_group(int unsigned step, int unsigned steps,
                                              fill_dir_e dir);
      return (dir == FILL_UP) ? step : steps - 1 - step;
   endfunction

endpackage

// File: rtl/col_token_ring.sv
module col_token_ring #(
   parameter int STEPS = 64
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             clr,
   input  logic             arm,
   output logic [STEPS-1:0] tok
);

   initial begin
      assert (STEPS >= 2) else $error("col_token_ring: STEPS must be at least 2");
   end

   // Shifting toward the top drops the token out after the last step: standby.
   always_ff @(posedge clk) begin
      if (rst) begin
         tok <= '0;
      end else if (clr) begin
         tok <= '0;
      end else if (arm) begin
         tok <= {{(STEPS-1){1'b0}}, 1'b1};
      end else begin
         tok <= tok << 1;
      end
   end

   a_r5_single_token: assert property (@(posedge clk) disable iff (rst)
      $onehot0(tok));

   a_r7_clear_empties: assert property (@(posedge clk) disable iff (rst)
      clr |=> (tok == '0));

   a_r8_last_once: assert property (@(posedge clk) disable iff (rst)
      tok[STEPS-1] |=> !tok[STEPS-1]);

endmodule

// File: rtl/col_word_cond.sv
module col_word_cond #(
   parameter int LANES  = 6,
   parameter int CODE_W = 6
) (
   input  logic                    inv,
   input  logic [LANES*CODE_W-1:0] din,
   output logic [LANES*CODE_W-1:0] dout
);

   initial begin
      assert (LANES >= 1 && CODE_W >= 1) else $error("col_word_cond: bad geometry");
   end

   for (genvar l = 0; l < LANES; l++) begin : g_lane
      assign dout[l*CODE_W +: CODE_W] = inv ? ~din[l*CODE_W +: CODE_W]
                                            :  din[l*CODE_W +: CODE_W];
   end

endmodule

// File: rtl/col_row_bank.sv
module col_row_bank #(
   parameter int GROUPS  = 64,
   parameter int GROUP_W = 36
) (
   input  logic                      clk,
   input  logic                      rst,
   input  logic [GROUPS-1:0]         we,
   input  logic [GROUP_W-1:0]        wdata,
   output logic [GROUPS*GROUP_W-1:0] row
);

   initial begin
      assert (GROUPS >= 1 && GROUP_W >= 1) else $error("col_row_bank: bad geometry");
   end

   for (genvar g = 0; g < GROUPS; g++) begin : g_grp
      always_ff @(posedge clk) begin
         if (rst) begin
            row[g*GROUP_W +: GROUP_W] <= '0;
         end else if (we[g]) begin
            row[g*GROUP_W +: GROUP_W] <= wdata;
         end
      end
   end

   a_r4_one_group: assert property (@(posedge clk) disable iff (rst)
      $onehot0(we));

   a_r5_row_holds: assert property (@(posedge clk) disable iff (rst)
      (we == '0) |=> $stable(row));

endmodule

// File: rtl/col_loader.sv
module col_loader
   import col_loader_pkg::*;
#(
   parameter int LANES    = 6,
   parameter int CODE_W   = 6,
   parameter int CHANNELS = 384
) (
   input  logic                       clk,
   input  logic                       rst,
   input  logic                       line_latch_i,
   input  logic                       dir_i,
   input  logic                       inv_i,
   input  logic [LANES*CODE_W-1:0]    pix_i,
   input  logic                       sp_a_i,
   output logic                       sp_a_o,
   output logic                       sp_a_oe,
   input  logic                       sp_b_i,
   output logic                       sp_b_o,
   output logic                       sp_b_oe,
   output logic [CHANNELS*CODE_W-1:0] row_o
);

   localparam int WORD_W = LANES * CODE_W;
   localparam int STEPS  = CHANNELS / LANES;

   initial begin
      assert (CHANNELS % LANES == 0) else $error("col_loader: CHANNELS not a multiple of LANES");
      assert (STEPS >= 2) else $error("col_loader: at least two capture steps required");
   end

   fill_dir_e          fdir;
   logic               latch_q;
   logic               latch_rise;
   logic               arm;
   logic               cascade;
   logic [STEPS-1:0]   tok;
   logic [STEPS-1:0]   we;
   logic [WORD_W-1:0]  word_c;

   assign fdir = fill_dir_e'(dir_i);

   always_ff @(posedge clk) begin
      if (rst) latch_q <= 1'b0;
      else     latch_q <= line_latch_i;
   end

   assign latch_rise = line_latch_i & ~latch_q;
   assign arm        = (fdir == FILL_UP) ? sp_a_i : sp_b_i;

   col_token_ring #(.STEPS(STEPS)) u_ring (
      .clk (clk),
      .rst (rst),
      .clr (latch_rise),
      .arm (arm),
      .tok (tok)
   );

   // Group g is written when the token sits on the step mapped to g.
   for (genvar g = 0; g < STEPS; g++) begin : g_map
      localparam int UP_IDX = slot_group(g, STEPS, FILL_UP);
      localparam int DN_IDX = slot_group(g, STEPS, FILL_DOWN);
      assign we[g] = ~latch_rise & ~arm &
                     ((fdir == FILL_UP) ? tok[UP_IDX] : tok[DN_IDX]);
   end

   col_word_cond #(.LANES(LANES), .CODE_W(CODE_W)) u_cond (
      .inv  (inv_i),
      .din  (pix_i),
      .dout (word_c)
   );

   col_row_bank #(.GROUPS(STEPS), .GROUP_W(WORD_W)) u_bank (
      .clk   (clk),
      .rst   (rst),
      .we    (we),
      .wdata (word_c),
      .row   (row_o)
   );

   assign cascade = tok[STEPS-1];
   assign sp_b_o  = (fdir == FILL_UP)   & cascade;
   assign sp_a_o  = (fdir == FILL_DOWN) & cascade;
   assign sp_b_oe = (fdir == FILL_UP);
   assign sp_a_oe = (fdir == FILL_DOWN);

   a_r2_first_group: assert property (@(posedge clk) disable iff (rst)
      (arm && !latch_rise) |=>
         (arm || latch_rise || ((fdir == FILL_UP) ? we[0] : we[STEPS-1])));

   a_r7_latch_stops: assert property (@(posedge clk) disable iff (rst)
      latch_rise |=> (tok == '0));

   a_r5_standby_after_last: assert property (@(posedge clk) disable iff (rst)
      (cascade && !arm && !latch_rise) |=> (we == '0));

   a_r8_pulse_width: assert property (@(posedge clk) disable iff (rst)
      (sp_a_o || sp_b_o) |=> !(sp_a_o || sp_b_o));

endmodule

// File: tb/col_loader_test.sv
module col_loader_test;

   localparam int CLK_PERIOD = 10;
   localparam int LANES  = 6;
   localparam int CODE_W = 6;
   localparam int CH     = 384;
   localparam int STEPS  = CH / LANES;
   localparam int WORD_W = LANES * CODE_W;
   localparam int ROW_W  = CH * CODE_W;

   // {dir, inversion mode (0 off, 1 on, 2 alternate per word), seed}
   localparam logic [9:0] VEC [6] = '{
      {1'b1, 2'd0, 7'd3},
      {1'b0, 2'd0, 7'd9},
      {1'b1, 2'd1, 7'd21},
      {1'b0, 2'd2, 7'd40},
      {1'b1, 2'd2, 7'd63},
      {1'b0, 2'd1, 7'd100}
   };

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic latch = 1'b0;
   logic dir = 1'b1;
   logic inv = 1'b0;
   logic [WORD_W-1:0] din = '0;
   logic spa_i = 1'b0, spb_i = 1'b0;
   logic spa_o, spa_oe, spb_o, spb_oe;
   logic [ROW_W-1:0] row;
   logic [ROW_W-1:0] exp_row = '0;
   int n_tests = 0;
   int n_fail  = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   col_loader uut (
      .clk(clk), .rst(rst), .line_latch_i(latch), .dir_i(dir), .inv_i(inv),
      .pix_i(din), .sp_a_i(spa_i), .sp_a_o(spa_o), .sp_a_oe(spa_oe),
      .sp_b_i(spb_i), .sp_b_o(spb_o), .sp_b_oe(spb_oe), .row_o(row)
   );

   function automatic logic [5:0] gen(int seed, int k, int j);
      int t;
      t = seed * 13 + k * 5 + j * 11 + k * j;
      return t[5:0];
   endfunction

   function automatic logic [WORD_W-1:0] word_of(int seed, int k);
      logic [WORD_W-1:0] w;
      for (int j = 0; j < LANES; j++) w[j*CODE_W +: CODE_W] = gen(seed, k, j);
      return w;
   endfunction

   task automatic check(bit ok, string tag, logic [63:0] act, logic [63:0] expv);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
      end
   endtask

   task automatic check_row(string tag);
      int bad;
      bad = -1;
      for (int c = CH - 1; c >= 0; c--)
         if (row[c*CODE_W +: CODE_W] !== exp_row[c*CODE_W +: CODE_W]) bad = c;
      if (bad < 0) check(1'b1, tag, 0, 0);
      else check(1'b0, $sformatf("%s channel %0d", tag, bad + 1),
                 64'(row[bad*CODE_W +: CODE_W]), 64'(exp_row[bad*CODE_W +: CODE_W]));
   endtask

   // Records word k of a line in the expected row (R1, R4, R6).
   task automatic expect_word(bit d, int k, logic [WORD_W-1:0] w, bit iv);
      int base;
      base = d ? k * LANES : (STEPS - 1 - k) * LANES;
      for (int j = 0; j < LANES; j++)
         exp_row[(base+j)*CODE_W +: CODE_W] = iv ? ~w[j*CODE_W +: CODE_W] : w[j*CODE_W +: CODE_W];
   endtask

   task automatic run_line(bit d, int mode, int seed);
      int highs, at, other;
      bit iv;
      highs = 0; at = -1; other = 0;
      @(negedge clk);
      dir = d;
      if (d) spa_i = 1'b1; else spb_i = 1'b1;
      din = ~word_of(seed, 0);             // R2: word on the start edge must be dropped
      inv = 1'b0;
      for (int k = 0; k < STEPS; k++) begin
         @(negedge clk);
         if (d ? spb_o : spa_o) begin highs++; at = k; end
         if (d ? spa_o : spb_o) other++;
         spa_i = 1'b0; spb_i = 1'b0;
         iv = (mode == 2) ? bit'(k % 2) : (mode == 1);
         inv = iv;
         din = word_of(seed, k);
         expect_word(d, k, din, iv);
      end
      @(negedge clk);
      if (d ? spb_o : spa_o) highs++;
      check(highs == 1 && at == STEPS - 1, "R8 cascade pulse step", 64'(at), 64'(STEPS - 1));
      check(other == 0, "R3 idle pin quiet", 64'(other), 0);
      check(spb_oe == d && spa_oe == !d, "R3 enables", {spb_oe, spa_oe}, {d, !d});
      check_row("R1 R2 R4 R6 line content");
      for (int i = 0; i < 4; i++) begin
         din = word_of(seed + 50, i);
         inv = bit'(i % 2);
         @(negedge clk);
         check_row("R5 standby");
      end
   endtask

   initial begin
      #(CLK_PERIOD * 100000);
      n_tests++; n_fail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst = 1'b0;
      @(negedge clk);
      check_row("R9 reset row");
      check(!spa_o && !spb_o, "R9 reset cascade", {spa_o, spb_o}, 0);
      check(spb_oe && !spa_oe, "R3 reset enables", {spb_oe, spa_oe}, 2'b10);

      foreach (VEC[i]) run_line(VEC[i][9], int'(VEC[i][8:7]), int'(VEC[i][6:0]));

      // R3: token on the output-side pin is ignored.
      @(negedge clk);
      dir = 1'b1; spb_i = 1'b1; din = word_of(5, 0);
      for (int k = 0; k < 5; k++) begin
         @(negedge clk);
         spb_i = 1'b0; din = word_of(5, k + 1);
      end
      @(negedge clk);
      check_row("R3 wrong pin ignored");

      // R7: latch rise mid-line.
      @(negedge clk);
      spa_i = 1'b1; din = word_of(77, 99); inv = 1'b0;
      for (int k = 0; k < 10; k++) begin
         @(negedge clk);
         spa_i = 1'b0; din = word_of(77, k);
         expect_word(1'b1, k, din, 1'b0);
      end
      @(negedge clk);
      latch = 1'b1; din = word_of(77, 10);
      @(negedge clk);
      check_row("R7 latch edge word dropped");
      for (int k = 11; k < 16; k++) begin
         din = word_of(77, k);
         @(negedge clk);
      end
      check_row("R7 no capture after latch");
      run_line(1'b1, 0, 88);               // R7: latch held high, start still works
      latch = 1'b0;

      // R9: reset in the middle of a line.
      @(negedge clk);
      spa_i = 1'b1;
      for (int k = 0; k < 5; k++) begin
         @(negedge clk);
         spa_i = 1'b0; din = word_of(12, k);
      end
      @(negedge clk);
      rst = 1'b1;
      @(negedge clk);
      rst = 1'b0;
      exp_row = '0;
      for (int k = 0; k < 3; k++) begin
         din = word_of(13, k);
         @(negedge clk);
      end
      check_row("R9 reset clears and stops");
      check(!spa_o && !spb_o, "R9 cascade low after reset", {spa_o, spb_o}, 0);

      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

endmodule